// File: doc/BRIEF.md
# ECC Error Status and Log Capture

This block keeps the sticky error flags that a memory controller raises when a DRAM read returns an ECC error, and a single log entry that describes the access behind the error. Each read that the ECC checker judges faulty arrives as a one-cycle strobe, either a correctable (single-bit) strobe or an uncorrectable (multi-bit) strobe. Each strobe comes with the access address, the channel number, the device number and the error syndrome.

Software reads the flags and the log through a small register port with one cycle of read latency. It clears each flag by writing a 1 to that flag's bit. The log follows a priority-lock rule. A pending single-bit flag shields the log only from further single-bit errors. A multi-bit error may replace a single-bit entry, and once it is logged it shields the log from every other error until software clears the multi-bit flag. A 2-bit kind field in the log tells software which class of error the stored address belongs to.

The flags and the log are cleared only by the power-good reset. The ordinary reset clears only the read-data register, so the error history survives a warm reset.

Top module: `ecc_err_log`

## Requirements
- R1: A single-bit strobe that finds both flags clear stores its address, channel, device and syndrome in the log and sets the single-bit flag.
- R2: While the single-bit flag is set and not being cleared, a single-bit strobe leaves every log field unchanged.
- R3: A multi-bit strobe that finds the multi-bit flag clear stores its address, channel, device and syndrome in the log and sets the multi-bit flag. This holds even when a single-bit entry is already logged.
- R4: While the multi-bit flag is set and not being cleared, no strobe of either kind changes any log field.
- R5: A write to select 0 clears the single-bit flag where data bit 0 is 1, and the multi-bit flag where data bit 1 is 1. Bits written as 0, and writes to any other select, change no flag.
- R6: An active-low power-good reset (pwr_good_n) clears both flags and the whole log at once. The active-low ordinary reset (rst_n) forces reg_rdata to 0 and leaves the flags and the log untouched.
- R7: The log kind field reads 2'b00 when nothing has been logged since power-good, 2'b01 when the entry came from a single-bit error, and 2'b10 when it came from a multi-bit error. Clearing a flag does not change the kind field.
- R8: When single-bit and multi-bit strobes arrive in the same cycle and the log is open to the multi-bit error, the multi-bit data is logged. Both flags are set in every case.
- R9: When the multi-bit flag is cleared while the single-bit flag stays set, the log stays closed to single-bit strobes but accepts the next multi-bit strobe.
- R10: A strobe in the same cycle as a write that clears the matching flag leaves that flag set. The strobe is logged if the log would be open once the clear takes effect.
- R11: reg_rdata shows, one cycle after reg_sel is presented, the state held before that edge. Select 0 gives {mbe flag at bit 1, sbe flag at bit 0}. Select 1 gives the log address. Select 2 gives {syndrome[12:5], device[4:3], channel[2], kind[1:0]}. Select 3 gives 0. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_n | input | 1 | Power-good reset, active low, asynchronous; clears flags and log |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; clears read data only |
| sbe_vld | input | 1 | Single-bit (corrected) error strobe for one read |
| sbe_addr | input | ADDR_W (32) | Address of the single-bit error access |
| sbe_chan | input | CHAN_W (1) | Channel of the single-bit error access |
| sbe_dev | input | DEV_W (2) | Device of the single-bit error access |
| sbe_syn | input | SYN_W (8) | Syndrome of the single-bit error |
| mbe_vld | input | 1 | Multi-bit (uncorrectable) error strobe for one read |
| mbe_addr | input | ADDR_W (32) | Address of the multi-bit error access |
| mbe_chan | input | CHAN_W (1) | Channel of the multi-bit error access |
| mbe_dev | input | DEV_W (2) | Device of the multi-bit error access |
| mbe_syn | input | SYN_W (8) | Syndrome of the multi-bit error |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for reads and writes |
| reg_wdata | input | 2 | Write-one-to-clear data for the flag bits |
| reg_rdata | output | DATA_W (32) | Registered read data |

## Verification
The hardest situations to reach are the ones where a software clear and an error strobe land on the same edge. Examples are clearing the multi-bit flag while a new multi-bit strobe arrives, and clearing everything while a single-bit strobe arrives. The lock state on that edge depends on the flag value that takes effect after the clear, not on the value stored before it. The stimulus reaches these cases with a drive task that puts a strobe and a status write in the same cycle. It first steers the flags into each combination: single only, both set, and multi cleared with single kept. A long random phase then mixes strobes, clears, selects and warm resets, while a behavioural model is compared with the read port on every clock.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

   // Log kind codes as seen by software
   typedef enum logic [1:0] {
      KIND_NONE   = 2'b00,
      KIND_SINGLE = 2'b01,
      KIND_MULTI  = 2'b10
   } log_kind_e;

   localparam int KIND_W = 2;
   localparam int SEL_W  = 2;
   localparam int FLAG_W = 2;

   // Register selects
   localparam logic [SEL_W-1:0] SEL_STATUS = 2'd0;
   localparam logic [SEL_W-1:0] SEL_ADDR   = 2'd1;
   localparam logic [SEL_W-1:0] SEL_INFO   = 2'd2;

   // Flag bit positions inside the status word
   localparam int BIT_SBE = 0;
   localparam int BIT_MBE = 1;

endpackage

// File: rtl/ecc_log_clr_dec.sv
module ecc_log_clr_dec
   import ecc_log_pkg::*;
(
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [FLAG_W-1:0] reg_wdata,
   output logic              clr_sbe,
   output logic              clr_mbe
);

   logic status_hit;

   assign status_hit = reg_wr && (reg_sel == SEL_STATUS);
   assign clr_sbe    = status_hit && reg_wdata[BIT_SBE];
   assign clr_mbe    = status_hit && reg_wdata[BIT_MBE];

endmodule

// File: rtl/ecc_log_arb.sv
module ecc_log_arb (
   input  logic sbe_vld,
   input  logic mbe_vld,
   input  logic sbe_flag,
   input  logic mbe_flag,
   input  logic clr_sbe,
   input  logic clr_mbe,
   output logic take_sbe,
   output logic take_mbe
);

   // Lock state after this cycle's clears take effect
   logic mbe_open;
   logic sbe_open;

   assign mbe_open = !mbe_flag || clr_mbe;
   assign sbe_open = (!sbe_flag || clr_sbe) && mbe_open;

   // Multi-bit wins over single-bit in the same cycle
   assign take_mbe = mbe_vld && mbe_open;
   assign take_sbe = sbe_vld && !mbe_vld && sbe_open;

endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CHAN_W  = 1,
   parameter int DEV_W   = 2,
   parameter int SYN_W   = 8,
   parameter bit LOG_SYN = 1'b1
) (
   input  logic              clk,
   input  logic              pwr_good_n,
   input  logic              sbe_vld,
   input  logic              mbe_vld,
   input  logic              take_sbe,
   input  logic              take_mbe,
   input  logic              clr_sbe,
   input  logic              clr_mbe,
   input  logic [ADDR_W-1:0] sbe_addr,
   input  logic [CHAN_W-1:0] sbe_chan,
   input  logic [DEV_W-1:0]  sbe_dev,
   input  logic [SYN_W-1:0]  sbe_syn,
   input  logic [ADDR_W-1:0] mbe_addr,
   input  logic [CHAN_W-1:0] mbe_chan,
   input  logic [DEV_W-1:0]  mbe_dev,
   input  logic [SYN_W-1:0]  mbe_syn,
   output logic              sbe_flag,
   output logic              mbe_flag,
   output logic [ADDR_W-1:0] log_addr,
   output logic [CHAN_W-1:0] log_chan,
   output logic [DEV_W-1:0]  log_dev,
   output logic [SYN_W-1:0]  log_syn,
   output log_kind_e         log_kind
);

   logic              capture;
   logic [ADDR_W-1:0] cap_addr;
   logic [CHAN_W-1:0] cap_chan;
   logic [DEV_W-1:0]  cap_dev;

   assign capture  = take_sbe || take_mbe;
   assign cap_addr = take_mbe ? mbe_addr : sbe_addr;
   assign cap_chan = take_mbe ? mbe_chan : sbe_chan;
   assign cap_dev  = take_mbe ? mbe_dev  : sbe_dev;

   // Sticky flags: a strobe always sets, a clear only acts without a strobe
   always_ff @(posedge clk or negedge pwr_good_n) begin
      if (!pwr_good_n) begin
         sbe_flag <= 1'b0;
         mbe_flag <= 1'b0;
      end else begin
         sbe_flag <= sbe_vld || (sbe_flag && !clr_sbe);
         mbe_flag <= mbe_vld || (mbe_flag && !clr_mbe);
      end
   end

   always_ff @(posedge clk or negedge pwr_good_n) begin
      if (!pwr_good_n) begin
         log_addr <= '0;
         log_chan <= '0;
         log_dev  <= '0;
         log_kind <= KIND_NONE;
      end else if (capture) begin
         log_addr <= cap_addr;
         log_chan <= cap_chan;
         log_dev  <= cap_dev;
         log_kind <= take_mbe ? KIND_MULTI : KIND_SINGLE;
      end
   end

   generate
      if (LOG_SYN) begin : g_syn
         always_ff @(posedge clk or negedge pwr_good_n) begin
            if (!pwr_good_n) begin
               log_syn <= '0;
            end else if (capture) begin
               log_syn <= take_mbe ? mbe_syn : sbe_syn;
            end
         end
      end else begin : g_nosyn
         assign log_syn = '0;
      end
   endgenerate

   // R1
   sbe_capture_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (sbe_vld && !mbe_vld && (!sbe_flag || clr_sbe) && (!mbe_flag || clr_mbe))
      |=> (sbe_flag && log_kind == KIND_SINGLE && log_addr == $past(sbe_addr)));

   // R2
   sbe_lock_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (sbe_flag && !clr_sbe && sbe_vld && !mbe_vld)
      |=> ($stable(log_addr) && $stable(log_dev) && $stable(log_chan) && $stable(log_kind)));

   // R3
   mbe_capture_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (mbe_vld && (!mbe_flag || clr_mbe))
      |=> (mbe_flag && log_kind == KIND_MULTI && log_addr == $past(mbe_addr)));

   // R4
   mbe_lock_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (mbe_flag && !clr_mbe)
      |=> ($stable(log_addr) && $stable(log_dev) && $stable(log_chan) && $stable(log_kind)));

   // R5
   w1c_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (clr_mbe && !mbe_vld) |=> !mbe_flag);

   // R10
   clr_race_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
      (clr_sbe && sbe_vld) |=> sbe_flag);

endmodule

// File: rtl/ecc_log_rdmux.sv
module ecc_log_rdmux
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CHAN_W = 1,
   parameter int DEV_W  = 2,
   parameter int SYN_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              sbe_flag,
   input  logic              mbe_flag,
   input  logic [ADDR_W-1:0] log_addr,
   input  logic [CHAN_W-1:0] log_chan,
   input  logic [DEV_W-1:0]  log_dev,
   input  logic [SYN_W-1:0]  log_syn,
   input  log_kind_e         log_kind,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int INFO_W = KIND_W + CHAN_W + DEV_W + SYN_W;

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      unique case (reg_sel)
         SEL_STATUS: begin
            rd_next[BIT_SBE] = sbe_flag;
            rd_next[BIT_MBE] = mbe_flag;
         end
         SEL_ADDR:   rd_next[ADDR_W-1:0] = log_addr;
         SEL_INFO:   rd_next[INFO_W-1:0] = {log_syn, log_dev, log_chan, log_kind};
         default:    rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else begin
         reg_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CHAN_W  = 1,
   parameter int DEV_W   = 2,
   parameter int SYN_W   = 8,
   parameter int DATA_W  = 32,
   parameter bit LOG_SYN = 1'b1
) (
   input  logic              clk,
   input  logic              pwr_good_n,
   input  logic              rst_n,
   input  logic              sbe_vld,
   input  logic [ADDR_W-1:0] sbe_addr,
   input  logic [CHAN_W-1:0] sbe_chan,
   input  logic [DEV_W-1:0]  sbe_dev,
   input  logic [SYN_W-1:0]  sbe_syn,
   input  logic              mbe_vld,
   input  logic [ADDR_W-1:0] mbe_addr,
   input  logic [CHAN_W-1:0] mbe_chan,
   input  logic [DEV_W-1:0]  mbe_dev,
   input  logic [SYN_W-1:0]  mbe_syn,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [FLAG_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int INFO_W = KIND_W + CHAN_W + DEV_W + SYN_W;

   initial begin : param_chk
      assert (ADDR_W <= DATA_W && ADDR_W > 0)
         else $fatal(1, "ecc_err_log: address wider than read data");
      assert (INFO_W <= DATA_W && CHAN_W > 0 && DEV_W > 0 && SYN_W > 0)
         else $fatal(1, "ecc_err_log: info word does not fit read data");
      assert (DATA_W >= FLAG_W)
         else $fatal(1, "ecc_err_log: read data narrower than status");
   end

   logic              clr_sbe, clr_mbe;
   logic              take_sbe, take_mbe;
   logic              sbe_flag, mbe_flag;
   logic [ADDR_W-1:0] log_addr;
   logic [CHAN_W-1:0] log_chan;
   logic [DEV_W-1:0]  log_dev;
   logic [SYN_W-1:0]  log_syn;
   log_kind_e         log_kind;

   ecc_log_clr_dec u_clr (
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .clr_sbe   (clr_sbe),
      .clr_mbe   (clr_mbe)
   );

   ecc_log_arb u_arb (
      .sbe_vld  (sbe_vld),
      .mbe_vld  (mbe_vld),
      .sbe_flag (sbe_flag),
      .mbe_flag (mbe_flag),
      .clr_sbe  (clr_sbe),
      .clr_mbe  (clr_mbe),
      .take_sbe (take_sbe),
      .take_mbe (take_mbe)
   );

   ecc_log_store #(
      .ADDR_W  (ADDR_W),
      .CHAN_W  (CHAN_W),
      .DEV_W   (DEV_W),
      .SYN_W   (SYN_W),
      .LOG_SYN (LOG_SYN)
   ) u_store (
      .clk        (clk),
      .pwr_good_n (pwr_good_n),
      .sbe_vld    (sbe_vld),
      .mbe_vld    (mbe_vld),
      .take_sbe   (take_sbe),
      .take_mbe   (take_mbe),
      .clr_sbe    (clr_sbe),
      .clr_mbe    (clr_mbe),
      .sbe_addr   (sbe_addr),
      .sbe_chan   (sbe_chan),
      .sbe_dev    (sbe_dev),
      .sbe_syn    (sbe_syn),
      .mbe_addr   (mbe_addr),
      .mbe_chan   (mbe_chan),
      .mbe_dev    (mbe_dev),
      .mbe_syn    (mbe_syn),
      .sbe_flag   (sbe_flag),
      .mbe_flag   (mbe_flag),
      .log_addr   (log_addr),
      .log_chan   (log_chan),
      .log_dev    (log_dev),
      .log_syn    (log_syn),
      .log_kind   (log_kind)
   );

   ecc_log_rdmux #(
      .ADDR_W (ADDR_W),
      .CHAN_W (CHAN_W),
      .DEV_W  (DEV_W),
      .SYN_W  (SYN_W),
      .DATA_W (DATA_W)
   ) u_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .sbe_flag  (sbe_flag),
      .mbe_flag  (mbe_flag),
      .log_addr  (log_addr),
      .log_chan  (log_chan),
      .log_dev   (log_dev),
      .log_syn   (log_syn),
      .log_kind  (log_kind),
      .reg_rdata (reg_rdata)
   );

endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;

   logic        clk = 1'b0;
   logic        pwr_good_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        sbe_vld = 1'b0;
   logic [31:0] sbe_addr = '0;
   logic [0:0]  sbe_chan = '0;
   logic [1:0]  sbe_dev = '0;
   logic [7:0]  sbe_syn = '0;
   logic        mbe_vld = 1'b0;
   logic [31:0] mbe_addr = '0;
   logic [0:0]  mbe_chan = '0;
   logic [1:0]  mbe_dev = '0;
   logic [7:0]  mbe_syn = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [1:0]  reg_wdata = '0;
   logic [31:0] reg_rdata;

   int    checks = 0;
   int    errors = 0;
   bit    started = 1'b0;
   bit    done = 1'b0;
   string phase = "R6";

   always #10 clk = ~clk;

   ecc_err_log u_ecc_err_log (
      .clk        (clk),
      .pwr_good_n (pwr_good_n),
      .rst_n      (rst_n),
      .sbe_vld    (sbe_vld),
      .sbe_addr   (sbe_addr),
      .sbe_chan   (sbe_chan),
      .sbe_dev    (sbe_dev),
      .sbe_syn    (sbe_syn),
      .mbe_vld    (mbe_vld),
      .mbe_addr   (mbe_addr),
      .mbe_chan   (mbe_chan),
      .mbe_dev    (mbe_dev),
      .mbe_syn    (mbe_syn),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata)
   );

   // Behavioural reference model
   bit          m_sbe, m_mbe;
   logic [31:0] m_addr;
   logic [0:0]  m_chan;
   logic [1:0]  m_dev;
   logic [7:0]  m_syn;
   logic [1:0]  m_kind;
   logic [31:0] exp_rd = '0;

   always @(posedge clk) begin : model
      bit cs, cm, m_open, s_open;
      if (!pwr_good_n) begin
         m_sbe = 0; m_mbe = 0; m_addr = '0; m_chan = '0;
         m_dev = '0; m_syn = '0; m_kind = 2'b00;
      end
      if (!rst_n) exp_rd = '0;
      else case (reg_sel)
         2'd0:    exp_rd = {30'd0, m_mbe, m_sbe};
         2'd1:    exp_rd = m_addr;
         2'd2:    exp_rd = {19'd0, m_syn, m_dev, m_chan, m_kind};
         default: exp_rd = '0;
      endcase
      if (pwr_good_n) begin
         cs = reg_wr && reg_sel == 2'd0 && reg_wdata[0];
         cm = reg_wr && reg_sel == 2'd0 && reg_wdata[1];
         m_open = !m_mbe || cm;
         s_open = (!m_sbe || cs) && m_open;
         if (mbe_vld && m_open) begin
            m_addr = mbe_addr; m_chan = mbe_chan; m_dev = mbe_dev;
            m_syn = mbe_syn; m_kind = 2'b10;
         end else if (sbe_vld && !mbe_vld && s_open) begin
            m_addr = sbe_addr; m_chan = sbe_chan; m_dev = sbe_dev;
            m_syn = sbe_syn; m_kind = 2'b01;
         end
         m_sbe = sbe_vld || (m_sbe && !cs);
         m_mbe = mbe_vld || (m_mbe && !cm);
      end
      started = 1'b1;
   end

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model (R11)
   always @(posedge clk) begin
      #5;
      if (started && !done) check(reg_rdata, exp_rd, {phase, " model"});
   end

   task automatic drive(input bit s, input bit m, input logic [31:0] as, input logic [31:0] am,
                        input bit wr, input logic [1:0] wd);
      @(negedge clk);
      sbe_vld = s; mbe_vld = m; sbe_addr = as; mbe_addr = am;
      reg_wr = wr; reg_sel = 2'd0; reg_wdata = wd;
      @(negedge clk);
      sbe_vld = 0; mbe_vld = 0; reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_sel = sel;
      @(negedge clk);
      check(reg_rdata, exp, req);
   endtask

   initial begin : watchdog
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      pwr_good_n = 1; rst_n = 1;
      phase = "R6";
      rd(2'd0, 32'h0, "R6 status after power-good");
      rd(2'd1, 32'h0, "R6 addr after power-good");
      rd(2'd2, 32'h0, "R7 kind none after power-good");

      phase = "R1";
      sbe_chan = 1; sbe_dev = 2; sbe_syn = 8'h5A;
      drive(1, 0, 32'h0000_1000, 32'h0, 0, 2'b00);
      rd(2'd0, 32'h1, "R1 sbe flag");
      rd(2'd1, 32'h0000_1000, "R1 addr");
      rd(2'd2, 32'h0000_0B55, "R7 single info");

      phase = "R2";
      sbe_chan = 0; sbe_dev = 3; sbe_syn = 8'hFF;
      drive(1, 0, 32'h0000_2000, 32'h0, 0, 2'b00);
      rd(2'd1, 32'h0000_1000, "R2 addr locked");
      rd(2'd2, 32'h0000_0B55, "R2 info locked");

      phase = "R3";
      mbe_chan = 0; mbe_dev = 1; mbe_syn = 8'h11;
      drive(0, 1, 32'h0, 32'h0000_3000, 0, 2'b00);
      rd(2'd0, 32'h3, "R3 both flags");
      rd(2'd1, 32'h0000_3000, "R3 addr overwritten");
      rd(2'd2, 32'h0000_022A, "R3 multi info");

      phase = "R4";
      drive(1, 0, 32'h0000_3100, 32'h0, 0, 2'b00);
      drive(0, 1, 32'h0, 32'h0000_3200, 0, 2'b00);
      rd(2'd1, 32'h0000_3000, "R4 addr locked");

      phase = "R5";
      drive(0, 0, 32'h0, 32'h0, 1, 2'b00);
      rd(2'd0, 32'h3, "R5 zero write keeps flags");
      @(negedge clk); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 2'b11;
      @(negedge clk); reg_wr = 0; reg_wdata = '0;
      rd(2'd0, 32'h3, "R5 other select ignored");
      drive(0, 0, 32'h0, 32'h0, 1, 2'b10);
      rd(2'd0, 32'h1, "R5 mbe cleared");

      phase = "R9";
      drive(1, 0, 32'h0000_3300, 32'h0, 0, 2'b00);
      rd(2'd1, 32'h0000_3000, "R9 still closed to sbe");
      drive(0, 1, 32'h0, 32'h0000_4000, 0, 2'b00);
      rd(2'd1, 32'h0000_4000, "R9 open to mbe");

      phase = "R8";
      drive(0, 0, 32'h0, 32'h0, 1, 2'b11);
      rd(2'd0, 32'h0, "R5 both cleared");
      rd(2'd2, 32'h0000_022A, "R7 kind kept after clear");
      drive(1, 1, 32'h0000_5000, 32'h0000_6000, 0, 2'b00);
      rd(2'd0, 32'h3, "R8 both flags");
      rd(2'd1, 32'h0000_6000, "R8 mbe logged");

      phase = "R10";
      drive(0, 1, 32'h0, 32'h0000_7000, 1, 2'b10);
      rd(2'd0, 32'h3, "R10 mbe stays set");
      rd(2'd1, 32'h0000_7000, "R10 mbe captured on clear");
      drive(1, 0, 32'h0000_8000, 32'h0, 1, 2'b11);
      rd(2'd0, 32'h1, "R10 sbe stays set");
      rd(2'd1, 32'h0000_8000, "R10 sbe captured on clear");

      phase = "R6";
      @(negedge clk); reg_sel = 2'd1; rst_n = 0;
      @(negedge clk); check(reg_rdata, 32'h0, "R6 rdata cleared by rst_n");
      rst_n = 1;
      rd(2'd0, 32'h1, "R6 flags kept over rst_n");
      rd(2'd1, 32'h0000_8000, "R6 log kept over rst_n");
      @(negedge clk); pwr_good_n = 0;
      @(negedge clk); pwr_good_n = 1;
      rd(2'd0, 32'h0, "R6 flags cleared by power-good");
      rd(2'd1, 32'h0, "R6 log cleared by power-good");

      phase = "R11";
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         sbe_vld = ($urandom % 4) == 0;
         mbe_vld = ($urandom % 9) == 0;
         sbe_addr = $urandom; mbe_addr = $urandom;
         sbe_chan = 1'($urandom); mbe_chan = 1'($urandom);
         sbe_dev = 2'($urandom); mbe_dev = 2'($urandom);
         sbe_syn = 8'($urandom); mbe_syn = 8'($urandom);
         reg_wr = ($urandom % 4) == 0;
         reg_sel = 2'($urandom);
         reg_wdata = 2'($urandom);
         rst_n = ($urandom % 97) != 0;
      end
      @(negedge clk);
      sbe_vld = 0; mbe_vld = 0; reg_wr = 0; rst_n = 1;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule